// File: doc/BRIEF.md
# Block-RAM-Friendly Fall-Through Queue

This block is a single-clock first-in first-out buffer. Its storage array is only ever read through a clocked read port, so it maps onto on-chip block RAM. A producer offers a word with `push_en` and may do so while `push_ready` is high. A consumer sees the oldest stored word on `pop_data` whenever `pop_valid` is high, with no request needed beforehand, and takes it with `pop_en`.

The registered read port is itself the output holding register. The word at the head of the queue sits in that register, and the control logic refills it from the array whenever it is empty or being consumed. Because of this, a word written into an empty queue needs one more clock to appear at the output than it would with a combinational array read. In exchange, steady streaming runs at one word per cycle in both directions.

The occupancy count covers every stored word, including the one in the output register. It is presented on three identical outputs: one shared, one for the write side and one for the read side. Width and depth are parameters. A depth of zero gives a queue that never accepts or offers anything.

Top module: `rdreg_fifo`

## Requirements
- R1: While `pop_valid` is high, `pop_data` already equals the oldest unread word, without any prior `pop_en`.
- R2: Words leave in exactly the order in which they were accepted.
- R3: When a word is accepted at a clock edge into an empty queue, `pop_valid` is still low after that edge and goes high after the next one.
- R4: When a pop is accepted while the level is at least 2, `pop_valid` stays high on the following cycle and shows the next word.
- R5: `push_en` while `push_ready` is low changes neither the level nor the stored contents.
- R6: `pop_en` while `pop_valid` is low changes neither the level nor the stored contents.
- R7: The level lies in 0..DEPTH and is the same on `fill`, `fill_wr` and `fill_rd`. `push_ready` is high exactly when the level is below DEPTH.
- R8: A push and a pop accepted in the same cycle both take effect, and the level stays the same.
- R9: The level equals the number of accepted pushes minus accepted pops since reset, and the word in the output register is included in it.
- R10: A synchronous active-high `rst` empties the queue: the level is 0, `pop_valid` is low and `push_ready` is high (for DEPTH > 0).
- R11: With DEPTH = 0, `push_ready` and `pop_valid` stay low and the level stays 0 permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_data | input | DATA_W | Word offered by the producer |
| push_en | input | 1 | Push request |
| push_ready | output | 1 | Space available; a push is accepted only when high |
| pop_data | output | DATA_W | Oldest unread word, valid while `pop_valid` is high |
| pop_en | input | 1 | Pop request |
| pop_valid | output | 1 | A word is present on `pop_data` |
| fill | output | lvl_w(DEPTH) | Number of unread words |
| fill_wr | output | lvl_w(DEPTH) | Write-side copy of the level |
| fill_rd | output | lvl_w(DEPTH) | Read-side copy of the level |

## Verification
A depth-4 queue is driven with four request mixes: push-heavy (so it fills and refuses writes), pop-heavy (so it drains and refuses reads), an even mix, and both strobes held high every cycle. A cycle-level model in the bench tracks the contents and the state of the output register. The push-heavy mix separates a correct refusal at full from an overwrite, and the pop-heavy mix exposes the extra cycle from empty to valid. The even mix and the saturated mix separate correct simultaneous push-and-pop from a lost or duplicated word. A mid-run reset and a depth-zero instance cover the emptied and degenerate states.

// File: rtl/rdreg_pkg.sv
package rdreg_pkg;
    // width of a level value able to hold 0..d
    function automatic int lvl_w(input int d);
        return (d > 0) ? $clog2(d + 1) : 1;
    endfunction

    // number of storage rows actually built (at least one)
    function automatic int mem_n(input int d);
        return (d > 0) ? d : 1;
    endfunction

    // pointer width for the storage rows
    function automatic int ptr_w(input int d);
        return (mem_n(d) > 1) ? $clog2(mem_n(d)) : 1;
    endfunction
endpackage

// File: rtl/rdreg_fifo_ptr.sv
module rdreg_fifo_ptr #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q == PW'(N - 1)) ptr_d = '0;
            else                     ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rdreg_fifo_ram.sv
module rdreg_fifo_ram #(
    parameter int DATA_W = 8,
    parameter int N      = 4,
    parameter int PW     = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [PW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rows [N];
    logic [DATA_W-1:0] rdata_q;

    // write port
    always_ff @(posedge clk) begin
        if (we) rows[waddr] <= wdata;
    end

    // clocked read port; this register is the output holding stage
    always_ff @(posedge clk) begin
        if (re) rdata_q <= rows[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rdreg_fifo.sv
module rdreg_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [DATA_W-1:0]                    push_data,
    input  logic                                 push_en,
    output logic                                 push_ready,
    output logic [DATA_W-1:0]                    pop_data,
    input  logic                                 pop_en,
    output logic                                 pop_valid,
    output logic [rdreg_pkg::lvl_w(DEPTH)-1:0]   fill,
    output logic [rdreg_pkg::lvl_w(DEPTH)-1:0]   fill_wr,
    output logic [rdreg_pkg::lvl_w(DEPTH)-1:0]   fill_rd
);
    localparam int LW    = rdreg_pkg::lvl_w(DEPTH);
    localparam int MEM_D = rdreg_pkg::mem_n(DEPTH);
    localparam int PW    = rdreg_pkg::ptr_w(DEPTH);

    typedef struct packed {
        logic [LW-1:0] fill;   // all unread words, output register included
        logic          vld;    // output register holds the head word
    } state_t;

    state_t        st_d, st_q;
    logic          has_room;
    logic          push_acc;
    logic          pop_acc;
    logic          load;
    logic [LW-1:0] mem_cnt;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    always_comb begin
        has_room = (DEPTH > 0) && (st_q.fill < LW'(DEPTH));
        mem_cnt  = st_q.fill - LW'(st_q.vld);
        push_acc = push_en && has_room;
        pop_acc  = pop_en && st_q.vld;
        // refill the output register when it is free or being consumed
        load     = (mem_cnt != '0) && (!st_q.vld || pop_acc);

        st_d = st_q;
        if (load)         st_d.vld = 1'b1;
        else if (pop_acc) st_d.vld = 1'b0;

        case ({push_acc, pop_acc})
            2'b10:   st_d.fill = st_q.fill + 1'b1;
            2'b01:   st_d.fill = st_q.fill - 1'b1;
            default: st_d.fill = st_q.fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    rdreg_fifo_ptr #(.N(MEM_D), .PW(PW)) u_wptr (
        .clk (clk),
        .rst (rst),
        .adv (push_acc),
        .ptr (wptr)
    );

    rdreg_fifo_ptr #(.N(MEM_D), .PW(PW)) u_rptr (
        .clk (clk),
        .rst (rst),
        .adv (load),
        .ptr (rptr)
    );

    rdreg_fifo_ram #(.DATA_W(DATA_W), .N(MEM_D), .PW(PW)) u_ram (
        .clk   (clk),
        .we    (push_acc),
        .waddr (wptr),
        .wdata (push_data),
        .re    (load),
        .raddr (rptr),
        .rdata (pop_data)
    );

    assign push_ready = has_room;
    assign pop_valid  = st_q.vld;
    assign fill       = st_q.fill;
    assign fill_wr    = st_q.fill;
    assign fill_rd    = st_q.fill;
endmodule

// File: rtl/rdreg_fifo_chk.sv
module rdreg_fifo_chk #(
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          push_en,
    input logic          push_ready,
    input logic          pop_en,
    input logic          pop_valid,
    input logic [LW-1:0] fill
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= LW'(DEPTH)); // R7

    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        (push_en && !push_ready && !(pop_en && pop_valid)) |=> $stable(fill)); // R5

    AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !pop_valid && !(push_en && push_ready)) |=> $stable(fill)); // R6

    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (push_en && push_ready && pop_en && pop_valid) |=> $stable(fill)); // R8

    AST_VALID_COUNTED: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> (fill != '0)); // R9

    AST_EMPTY_WRITE_LAT: assert property (@(posedge clk) disable iff (rst)
        ((fill == '0) && push_en) |=> !pop_valid); // R3

    AST_POP_NEXT_READY: assert property (@(posedge clk) disable iff (rst)
        (pop_en && pop_valid && (fill >= LW'(2))) |=> pop_valid); // R4
endmodule

bind rdreg_fifo rdreg_fifo_chk #(
    .DEPTH (DEPTH),
    .LW    (rdreg_pkg::lvl_w(DEPTH))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_en    (push_en),
    .push_ready (push_ready),
    .pop_en     (pop_en),
    .pop_valid  (pop_valid),
    .fill       (fill)
);

// File: tb/rdreg_fifo_test.sv
module rdreg_fifo_test;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int LW = rdreg_pkg::lvl_w(DP);
    localparam int LZ = rdreg_pkg::lvl_w(0);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] push_data = '0;
    logic          push_en = 1'b0;
    logic          pop_en = 1'b0;
    logic          push_ready, pop_valid;
    logic [DW-1:0] pop_data;
    logic [LW-1:0] fill, fill_wr, fill_rd;

    logic          z_push_ready, z_pop_valid;
    logic [DW-1:0] z_pop_data;
    logic [LZ-1:0] z_fill, z_fill_wr, z_fill_rd;

    always #5 clk = ~clk;

    rdreg_fifo #(.DATA_W(DW), .DEPTH(DP)) uut (
        .clk(clk), .rst(rst), .push_data(push_data), .push_en(push_en),
        .push_ready(push_ready), .pop_data(pop_data), .pop_en(pop_en),
        .pop_valid(pop_valid), .fill(fill), .fill_wr(fill_wr), .fill_rd(fill_rd));

    rdreg_fifo #(.DATA_W(DW), .DEPTH(0)) uut_zero (
        .clk(clk), .rst(rst), .push_data(push_data), .push_en(push_en),
        .push_ready(z_push_ready), .pop_data(z_pop_data), .pop_en(pop_en),
        .pop_valid(z_pop_valid), .fill(z_fill), .fill_wr(z_fill_wr), .fill_rd(z_fill_rd));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int mq [16];
    int mhead = 0;
    int mfill = 0;
    bit mvld  = 1'b0;
    // tags derived from the previous cycle's stimulus
    string fill_tag = "R9";
    string vld_tag  = "R1";
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic check_outputs();
        chk(fill_tag, int'(fill), mfill);
        chk("R7", int'(fill_wr), mfill);
        chk("R7", int'(fill_rd), mfill);
        chk("R7", int'(push_ready), (mfill < DP) ? 1 : 0);
        chk(vld_tag, int'(pop_valid), int'(mvld));
        if (mvld) chk("R2", int'(pop_data), mq[mhead]);
        chk("R11", int'(z_push_ready), 0);
        chk("R11", int'(z_pop_valid), 0);
        chk("R11", int'(z_fill), 0);
    endtask

    // one cycle: called at a negedge, returns at the next negedge
    task automatic cycle(input bit pe, input bit po, input logic [DW-1:0] d);
        bit acc_push, acc_pop, load;
        int memc;
        check_outputs();
        push_en   = pe;
        pop_en    = po;
        push_data = d;
        acc_push = pe && (mfill < DP);
        acc_pop  = po && mvld;
        memc     = mfill - int'(mvld);
        load     = (memc > 0) && (!mvld || acc_pop);
        if (pe && !acc_push && !acc_pop)     fill_tag = "R5";
        else if (po && !acc_pop && !acc_push) fill_tag = "R6";
        else if (acc_push && acc_pop)         fill_tag = "R8";
        else                                  fill_tag = "R9";
        if (acc_push && mfill == 0)           vld_tag = "R3";
        else if (acc_pop && mfill >= 2)       vld_tag = "R4";
        else                                  vld_tag = "R1";
        if (acc_push) mq[(mhead + mfill) % 16] = int'(d);
        if (acc_pop)  mhead = (mhead + 1) % 16;
        mfill = mfill + int'(acc_push) - int'(acc_pop);
        if (load)         mvld = 1'b1;
        else if (acc_pop) mvld = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push_en = 1'b0;
        pop_en  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mhead = 0; mfill = 0; mvld = 1'b0;
        chk("R10", int'(fill), 0);
        chk("R10", int'(pop_valid), 0);
        chk("R10", int'(push_ready), 1);
        fill_tag = "R9";
        vld_tag  = "R1";
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // targeted latency: one word into an empty queue
        cycle(1'b1, 1'b0, 8'h5A);
        chk("R3", int'(pop_valid), 0);
        cycle(1'b0, 1'b0, 8'h00);
        chk("R3", int'(pop_valid), 1);
        chk("R1", int'(pop_data), 8'h5A);
        // request-mix sweeps
        for (int mode = 0; mode < 4; mode++) begin
            for (int i = 0; i < 300; i++) begin
                bit pe, po;
                step_lfsr();
                case (mode)
                    0: begin pe = (lfsr[1:0] != 2'b00); po = (lfsr[3:2] == 2'b00); end
                    1: begin pe = (lfsr[1:0] == 2'b00); po = (lfsr[3:2] != 2'b00); end
                    2: begin pe = lfsr[0];              po = lfsr[5];              end
                    default: begin pe = 1'b1;           po = 1'b1;                 end
                endcase
                cycle(pe, po, lfsr[15:8]);
            end
            if (mode == 2) do_reset();
        end
        // fill to the top, then push against full
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, 8'(8'h80 + i));
        chk("R5", int'(fill), DP);
        // drain completely, then pop against empty
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 8'h00);
        chk("R6", int'(fill), 0);
        check_outputs();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule